// File: doc/BRIEF.md
# Dual-Port Aliased Control Register Bank

This block is a bank of 64-bit control and status registers that two requesters reach at once. A scan-style port selects a register by byte address divided by eight. A memory-mapped port selects it by byte offset, and that offset is translated onto the same register indices with a fixed bias of 0x0A. Every access carries a full 8-byte word. Read data is returned one cycle after the request, together with a valid strobe.

The bank holds these registers: a fault-isolation register with AND and OR write aliases, a pair of action registers, a base-address register with an enable bit, a second base register, a control/status register with set and clear aliases, a status/error mask, a DMA upper-address word, a read-only interrupt status word and a source-compare register. Several registers keep only certain bits. The base-address register accepts writes only from the scan port. The block drives out the current base address and its enable. It gives a one-cycle pulse whenever a write flips the MMIO-enable bit (bit 62) of control/status. It also raises a one-cycle error flag for each illegal access.

Top module: `ctrl_reg_bank`

## Requirements
- R1: A synchronous reset clears every register to zero, except the base-address register. That register loads BASE_DEFAULT masked to bits 49..20 with bit 0 (enable) set. After reset, base_addr equals BASE_DEFAULT and base_en is 1.
- R2: A read request produces rsp_valid high for exactly one cycle, on the clock edge after the request edge, with rsp_data holding the register value. Write requests produce no rsp_valid. Reading an index that is not backed by a register returns all ones. The alias indices 0x01, 0x02, 0x12 and 0x13 count as not backed.
- R3: The scan port uses index = scan_addr >> 3. The memory-mapped port uses index = (mm_addr >> 3) + 0x0A. An address whose low three bits are not zero selects no register: a read of it returns all ones and a write to it has no effect.
- R4: A write to index 0x01 sets fault = fault & data. A write to index 0x02 sets fault = fault | data. A write to index 0x00 replaces the fault word.
- R5: A write to index 0x12 sets control = control | data. A write to index 0x13 sets control = control & ~data. A write to index 0x0E replaces the control word.
- R6: The base-address register (index 0x0A) keeps only the bits in mask 0x0003_FFFF_FFF0_0001. Only a scan-port write changes it. A memory-mapped write to it is dropped, and err_base_wr pulses for one cycle on the next edge. base_addr is the stored value with bit 0 cleared, and base_en is bit 0.
- R7: The second base register (index 0x0B) keeps only the bits in 0x0003_FFFF_0000_0000. The source-compare register (index 0x1B) keeps only its 19-bit compare field at bits 63..45 and its flag bits 35..32, which is mask 0xFFFF_E00F_0000_0000.
- R8: The interrupt status word (index 0x15) reads as zero. A write to it from either port changes nothing, and err_ro_wr pulses for one cycle.
- R9: mmio_chg pulses for one cycle, in the same cycle the new control value becomes visible, exactly when a write (plain, set or clear) flips control bit 62.
- R10: When both ports request in the same cycle, only the scan request is served. The memory-mapped request is discarded, with no write and no response, and err_collide pulses for one cycle.
- R11: The action registers (0x06, 0x07), the status/error mask (0x0F) and the DMA upper-address word (0x14) store and return all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_req | input | 1 | Scan-port request |
| scan_we | input | 1 | Scan-port write (1) or read (0) |
| scan_addr | input | ADDR_W | Scan-port byte address |
| scan_wdata | input | 64 | Scan-port write data |
| mm_req | input | 1 | Memory-mapped request |
| mm_we | input | 1 | Memory-mapped write (1) or read (0) |
| mm_addr | input | ADDR_W | Memory-mapped byte offset |
| mm_wdata | input | 64 | Memory-mapped write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the request |
| rsp_data | output | 64 | Read data |
| base_addr | output | 64 | Current base address, enable bit cleared |
| base_en | output | 1 | Base-address enable |
| mmio_chg | output | 1 | Pulse when control bit 62 flips |
| err_base_wr | output | 1 | Pulse on a memory-mapped base-register write |
| err_ro_wr | output | 1 | Pulse on a write to interrupt status |
| err_collide | output | 1 | Pulse when a memory-mapped request loses to the scan port |

## Verification
Directed sequences run each alias against a register preloaded with a mixed bit pattern, so that AND, OR, set and clear each give a different result from a plain write. The same registers are reached through both ports: a swapped offset bias or a wrong shift then shows up as data from the wrong register. Control writes that flip bit 62, and others that leave it unchanged, separate a change detector from a level or write detector. All-ones writes to the masked registers expose each kept bit. A long stretch of pseudo-random mixed traffic, with simultaneous requests on both ports, checks arbitration and read timing against the behavioural model on every clock.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef logic [63:0] word_t;

  // register indices (shared by both ports after address translation)
  localparam int FAULT_IX = 'h00;
  localparam int FAND_IX  = 'h01;
  localparam int FOR_IX   = 'h02;
  localparam int ACT0_IX  = 'h06;
  localparam int ACT1_IX  = 'h07;
  localparam int BASE_IX  = 'h0A;
  localparam int BASE2_IX = 'h0B;
  localparam int CTL_IX   = 'h0E;
  localparam int SEMR_IX  = 'h0F;
  localparam int CSET_IX  = 'h12;
  localparam int CCLR_IX  = 'h13;
  localparam int DMA_IX   = 'h14;
  localparam int ISTAT_IX = 'h15;
  localparam int CMP_IX   = 'h1B;

  // memory-mapped offset bias onto the index space
  localparam int MM_BIAS  = 'h0A;

  // kept-bit masks
  localparam word_t BASE_KEEP  = 64'h0003_FFFF_FFF0_0001;
  localparam word_t BASE2_KEEP = 64'h0003_FFFF_0000_0000;
  localparam word_t CMP_KEEP   = 64'hFFFF_E00F_0000_0000;
endpackage

// File: rtl/crb_port_map.sv
module crb_port_map #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 6,
  parameter int BIAS   = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] word_ix;

  // R3: byte address to word index plus bias; misaligned selects no register
  assign word_ix = IDX_W'(addr[ADDR_W-1:3]) + IDX_W'(BIAS);
  assign idx     = (addr[2:0] == 3'd0) ? word_ix : '1;
endmodule

// File: rtl/crb_regfile.sv
module crb_regfile
  import crb_pkg::*;
#(
  parameter int    IDX_W        = 6,
  parameter int    MMIO_BIT     = 62,
  parameter word_t BASE_DEFAULT = 64'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_mm,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output word_t            rd_data,
  output word_t            base_q,
  output logic             mmio_chg,
  output logic             err_base,
  output logic             err_ro
);
  word_t fault_q, base2_q, ctl_q, semr_q, dma_q, cmp_q;
  word_t act_q [2];
  word_t ctl_nx, rd_word;

  // control/status next value including the set/clear aliases (R5)
  always_comb begin
    ctl_nx = ctl_q;
    if (wr_en) begin
      case (wr_idx)
        IDX_W'(CTL_IX):  ctl_nx = wr_data;
        IDX_W'(CSET_IX): ctl_nx = ctl_q | wr_data;
        IDX_W'(CCLR_IX): ctl_nx = ctl_q & ~wr_data;
        default:         ctl_nx = ctl_q;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      IDX_W'(FAULT_IX): rd_word = fault_q;
      IDX_W'(ACT0_IX):  rd_word = act_q[0];
      IDX_W'(ACT1_IX):  rd_word = act_q[1];
      IDX_W'(BASE_IX):  rd_word = base_q;
      IDX_W'(BASE2_IX): rd_word = base2_q;
      IDX_W'(CTL_IX):   rd_word = ctl_q;
      IDX_W'(SEMR_IX):  rd_word = semr_q;
      IDX_W'(DMA_IX):   rd_word = dma_q;
      IDX_W'(ISTAT_IX): rd_word = '0;
      IDX_W'(CMP_IX):   rd_word = cmp_q;
      default:          rd_word = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q  <= '0;
      act_q[0] <= '0;
      act_q[1] <= '0;
      base_q   <= (BASE_DEFAULT & BASE_KEEP) | 64'd1;
      base2_q  <= '0;
      ctl_q    <= '0;
      semr_q   <= '0;
      dma_q    <= '0;
      cmp_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      mmio_chg <= 1'b0;
      err_base <= 1'b0;
      err_ro   <= 1'b0;
    end else begin
      ctl_q    <= ctl_nx;
      mmio_chg <= ctl_nx[MMIO_BIT] ^ ctl_q[MMIO_BIT];
      err_base <= wr_en && wr_mm && (wr_idx == IDX_W'(BASE_IX));
      err_ro   <= wr_en && (wr_idx == IDX_W'(ISTAT_IX));
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_word;
      if (wr_en) begin
        case (wr_idx)
          IDX_W'(FAULT_IX): fault_q  <= wr_data;
          IDX_W'(FAND_IX):  fault_q  <= fault_q & wr_data;
          IDX_W'(FOR_IX):   fault_q  <= fault_q | wr_data;
          IDX_W'(ACT0_IX):  act_q[0] <= wr_data;
          IDX_W'(ACT1_IX):  act_q[1] <= wr_data;
          IDX_W'(BASE_IX):  if (!wr_mm) base_q <= wr_data & BASE_KEEP;
          IDX_W'(BASE2_IX): base2_q  <= wr_data & BASE2_KEEP;
          IDX_W'(SEMR_IX):  semr_q   <= wr_data;
          IDX_W'(DMA_IX):   dma_q    <= wr_data;
          IDX_W'(CMP_IX):   cmp_q    <= wr_data & CMP_KEEP;
          default: ;
        endcase
      end
    end
  end

  // R4: after an OR-alias write every data bit is set in fault
  a_r4_or_alias_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(FOR_IX)) |=> ((fault_q & $past(wr_data)) == $past(wr_data)));

  // R5: after a clear-alias write no data bit remains in control
  a_r5_clr_alias_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(CCLR_IX)) |=> ((ctl_q & $past(wr_data)) == '0));

  // R6: memory-mapped writes never move the base register
  a_r6_mm_base_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_mm && wr_idx == IDX_W'(BASE_IX)) |=> $stable(base_q));

  // R9: a pulse only accompanies a real flip of the MMIO-enable bit
  a_r9_pulse_on_flip: assert property (@(posedge clk) disable iff (rst)
    mmio_chg |-> (ctl_q[MMIO_BIT] != $past(ctl_q[MMIO_BIT])));
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import crb_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          MMIO_BIT     = 62,
  parameter logic [63:0] BASE_DEFAULT = 64'h0000_0123_4560_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_req,
  input  logic              scan_we,
  input  logic [ADDR_W-1:0] scan_addr,
  input  logic [63:0]       scan_wdata,
  input  logic              mm_req,
  input  logic              mm_we,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [63:0]       mm_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic [63:0]       base_addr,
  output logic              base_en,
  output logic              mmio_chg,
  output logic              err_base_wr,
  output logic              err_ro_wr,
  output logic              err_collide
);
  localparam int IDX_W = ADDR_W - 2;  // one bit of headroom for the bias

  logic [IDX_W-1:0] scan_idx, mm_idx, sel_idx;
  logic             mm_go, sel_we, sel_go;
  word_t            sel_data, base_q;

  crb_port_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BIAS(0)) i_scan_map (
    .addr(scan_addr), .idx(scan_idx));
  crb_port_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BIAS(MM_BIAS)) i_mm_map (
    .addr(mm_addr), .idx(mm_idx));

  // R10: fixed priority, the scan port wins a same-cycle clash
  assign mm_go    = mm_req && !scan_req;
  assign sel_go   = scan_req || mm_go;
  assign sel_we   = scan_req ? scan_we : mm_we;
  assign sel_idx  = scan_req ? scan_idx : mm_idx;
  assign sel_data = scan_req ? scan_wdata : mm_wdata;

  crb_regfile #(.IDX_W(IDX_W), .MMIO_BIT(MMIO_BIT), .BASE_DEFAULT(BASE_DEFAULT)) i_regs (
    .clk(clk), .rst(rst),
    .wr_en(sel_go && sel_we), .wr_mm(mm_go), .wr_idx(sel_idx), .wr_data(sel_data),
    .rd_en(sel_go && !sel_we), .rd_idx(sel_idx),
    .rd_valid(rsp_valid), .rd_data(rsp_data),
    .base_q(base_q), .mmio_chg(mmio_chg),
    .err_base(err_base_wr), .err_ro(err_ro_wr));

  always_ff @(posedge clk) begin
    if (rst) err_collide <= 1'b0;
    else     err_collide <= scan_req && mm_req;
  end

  assign base_addr = {base_q[63:1], 1'b0};
  assign base_en   = base_q[0];

  // R2: a response follows exactly one served read
  a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past((scan_req && !scan_we) || (mm_req && !scan_req && !mm_we)));

  // R10: a clash flag only follows a cycle with both ports requesting
  a_r10_clash_flag: assert property (@(posedge clk) disable iff (rst)
    err_collide |-> $past(scan_req && mm_req));
endmodule

// File: tb/test_ctrl_reg_bank.sv
`timescale 1ns/1ps
module test_ctrl_reg_bank;
  localparam logic [63:0] BDEF = 64'h0000_0123_4560_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0, rst = 1'b1;
  logic scan_req = 0, scan_we = 0, mm_req = 0, mm_we = 0;
  logic [7:0] scan_addr = 0, mm_addr = 0;
  logic [63:0] scan_wdata = 0, mm_wdata = 0;
  logic rsp_valid, base_en, mmio_chg, err_base_wr, err_ro_wr, err_collide;
  logic [63:0] rsp_data, base_addr;

  always #2 clk = ~clk;  // 250 MHz

  ctrl_reg_bank #(.ADDR_W(8), .MMIO_BIT(62), .BASE_DEFAULT(BDEF)) i_ctrl_reg_bank (
    .clk(clk), .rst(rst),
    .scan_req(scan_req), .scan_we(scan_we), .scan_addr(scan_addr), .scan_wdata(scan_wdata),
    .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .base_addr(base_addr), .base_en(base_en),
    .mmio_chg(mmio_chg), .err_base_wr(err_base_wr), .err_ro_wr(err_ro_wr),
    .err_collide(err_collide));

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R1";

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [63:0] mdl [64];
  logic [63:0] e_rd = 0, wd, oldc;
  bit e_rv, e_tog, e_eb, e_ro, e_col, go, we, mm;
  int ix;

  function automatic bit backed(int i);
    return i == 0 || i == 6 || i == 7 || i == 10 || i == 11 || i == 14 ||
           i == 15 || i == 20 || i == 21 || i == 27;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mdl[i] = 64'd0;
      mdl[10] = BDEF | 64'd1;
      e_rv = 0; e_tog = 0; e_eb = 0; e_ro = 0; e_col = 0; e_rd = 0;
    end else begin
      e_col = scan_req && mm_req;
      go = scan_req || mm_req;
      mm = !scan_req && mm_req;
      we = scan_req ? scan_we : mm_we;
      wd = scan_req ? scan_wdata : mm_wdata;
      if (scan_req) ix = (scan_addr % 8 != 0) ? 63 : scan_addr / 8;
      else          ix = (mm_addr % 8 != 0) ? 63 : mm_addr / 8 + 10;
      e_rv = go && !we;
      if (e_rv) e_rd = (ix == 21) ? 64'd0 : (backed(ix) ? mdl[ix] : ONES);
      e_eb = go && we && mm && ix == 10;
      e_ro = go && we && ix == 21;
      oldc = mdl[14];
      if (go && we) begin
        case (ix)
          0: mdl[0] = wd;
          1: mdl[0] = mdl[0] & wd;
          2: mdl[0] = mdl[0] | wd;
          6, 7, 15, 20: mdl[ix] = wd;
          10: if (!mm) mdl[10] = wd & 64'h0003_FFFF_FFF0_0001;
          11: mdl[11] = wd & 64'h0003_FFFF_0000_0000;
          14: mdl[14] = wd;
          18: mdl[14] = mdl[14] | wd;
          19: mdl[14] = mdl[14] & ~wd;
          27: mdl[27] = wd & 64'hFFFF_E00F_0000_0000;
          default: ;
        endcase
      end
      e_tog = oldc[62] != mdl[14][62];
    end
    #1;
    check("R2 rsp_valid", {63'd0, rsp_valid}, {63'd0, e_rv});
    if (e_rv) check(cur_tag, rsp_data, e_rd);
    check("R6 base_addr", base_addr, mdl[10] & ~64'd1);
    check("R6 base_en", {63'd0, base_en}, {63'd0, mdl[10][0]});
    check("R9 mmio_chg", {63'd0, mmio_chg}, {63'd0, e_tog});
    check("R6 err_base_wr", {63'd0, err_base_wr}, {63'd0, e_eb});
    check("R8 err_ro_wr", {63'd0, err_ro_wr}, {63'd0, e_ro});
    check("R10 err_collide", {63'd0, err_collide}, {63'd0, e_col});
  end

  task automatic op(bit on_mm, bit w, logic [7:0] a, logic [63:0] d, string tag);
    @(negedge clk);
    cur_tag = tag;
    scan_req = !on_mm; scan_we = w; scan_addr = a; scan_wdata = d;
    mm_req = on_mm;    mm_we = w;   mm_addr = a;   mm_wdata = d;
  endtask

  task automatic both(bit sw, logic [7:0] sa, logic [63:0] sd,
                      bit mw, logic [7:0] ma, logic [63:0] md, string tag);
    @(negedge clk);
    cur_tag = tag;
    scan_req = 1; scan_we = sw; scan_addr = sa; scan_wdata = sd;
    mm_req = 1;   mm_we = mw;   mm_addr = ma;   mm_wdata = md;
  endtask

  task automatic idle();
    @(negedge clk);
    scan_req = 0; mm_req = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state at the ports
    check("R1 base_en", {63'd0, base_en}, 64'd1);
    check("R1 base_addr", base_addr, BDEF);
    op(0, 0, 8'h50, 0, "R1 base read");
    op(0, 0, 8'h70, 0, "R1 ctl read");
    // R11 full-width registers, R3 aliasing across ports
    op(0, 1, 8'h30, 64'hDEAD_BEEF_0123_4567, "R11");
    op(0, 1, 8'h38, 64'h8000_0000_0000_0001, "R11");
    op(0, 0, 8'h30, 0, "R11 act0");
    op(0, 0, 8'h38, 0, "R11 act1");
    op(0, 1, 8'hA0, 64'hA5A5_5A5A_F00D_CAFE, "R11");
    op(1, 0, 8'h50, 0, "R3 dma via mm");
    op(1, 1, 8'h28, 64'h1357_9BDF_2468_ACE0, "R3");
    op(0, 0, 8'h78, 0, "R3 semr via scan");
    // R4 fault aliases
    op(0, 1, 8'h00, 64'hF0F0_F0F0_F0F0_F0F0, "R4");
    op(0, 1, 8'h10, 64'h0000_0000_0000_00FF, "R4");
    op(0, 0, 8'h00, 0, "R4 after OR");
    op(0, 1, 8'h08, 64'hFF00_FF00_FF00_FF0F, "R4");
    op(0, 0, 8'h00, 0, "R4 after AND");
    // R5 control aliases, R9 toggle
    op(1, 1, 8'h20, 64'h0000_1111_0000_0003, "R5");
    op(1, 1, 8'h40, 64'h4000_0000_0000_0100, "R9 set flips");
    op(0, 1, 8'h90, 64'h4000_0000_0000_0000, "R9 set no flip");
    op(0, 0, 8'h70, 0, "R5 after set");
    op(0, 1, 8'h98, 64'h4000_0000_0000_0001, "R9 clear flips");
    op(1, 1, 8'h48, 64'h0000_0101_0000_0000, "R5");
    op(0, 0, 8'h70, 0, "R5 after clear");
    // R6 base register
    op(0, 1, 8'h50, ONES, "R6");
    op(1, 1, 8'h00, 64'h0, "R6 mm write dropped");
    op(0, 0, 8'h50, 0, "R6 masked base");
    op(0, 1, 8'h50, 64'h0000_0000_0010_0000, "R6 disable");
    // R7 masks
    op(0, 1, 8'h58, ONES, "R7");
    op(1, 0, 8'h08, 0, "R7 base2 mask");
    op(0, 1, 8'hD8, ONES, "R7");
    op(1, 0, 8'h88, 0, "R7 compare mask");
    // R8 read-only status
    op(0, 1, 8'hA8, ONES, "R8");
    op(1, 1, 8'h58, ONES, "R8");
    op(1, 0, 8'h58, 0, "R8 status reads zero");
    // R2 unbacked reads, R3 misaligned
    op(0, 0, 8'h08, 0, "R2 alias reads ones");
    op(1, 0, 8'hF8, 0, "R2 unbacked reads ones");
    op(1, 1, 8'h21, 64'h4000_0000_0000_0000, "R3 misaligned write");
    op(1, 0, 8'h21, 0, "R3 misaligned read");
    op(1, 0, 8'h20, 0, "R3 ctl unchanged");
    // R10 collisions
    both(0, 8'h70, 0, 1, 8'h20, 64'h4000_0000_0000_0000, "R10 scan read wins");
    both(1, 8'h00, 64'h1, 1, 8'h10, 64'hFFFF, "R10");
    op(0, 0, 8'h00, 0, "R10 only scan write landed");
    both(1, 8'hA0, 64'h7, 0, 8'h50, 0, "R10 mm read dropped");
    idle();
    // mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      int k = $urandom % 16;
      a = (k < 14) ? 8'((k < 8 ? k : k + 6) * 8) : 8'($urandom);
      case ($urandom % 5)
        0: op(1, 1, a, {$urandom, $urandom}, "R3 mixed");
        1: op(0, 1, a, {$urandom, $urandom}, "R4 mixed");
        2: op(0, 0, a, 0, "R2 mixed");
        3: op(1, 0, a, 0, "R3 mixed");
        default: both($urandom % 2 == 1, a, {$urandom, $urandom},
                      $urandom % 2 == 1, 8'(a + 8), {$urandom, $urandom}, "R10 mixed");
      endcase
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule